// File: doc/BRIEF.md
# DRAM Request Scheduler with Write Drain

This block sits in front of a single-channel DRAM and decides which pending request goes next. Reads and writes are accepted into two separate age-ordered queues. One selected request at a time is presented on a valid/ready output. The block tracks, per rank and bank, which row is believed open. It can pick strictly by age, or prefer the oldest request that targets an already open row. It falls back to the oldest request when nothing hits an open row.

Writes are normally held back behind reads. When the write queue fills past a percentage of its depth, the block enters a drain phase and issues writes first. Draining stops once the write count falls below half of the entry mark. Each change of direction between reads and writes costs a fixed turnaround gap. A read whose full address equals a queued write is answered from the write queue. Such a read is reported on a separate forward output and never reaches DRAM. The page policy is chosen at run time: the open policy leaves the row open after an issue, and the close policy marks it closed. A feedback input lets the command layer report rows that it opened or closed on its own.

Top module: `dram_req_sched`

## Requirements
- R1: `rd_ready` is low exactly when the read queue holds DEPTH (32) entries, and `wr_ready` is low exactly when the write queue holds DEPTH entries. A request offered while its ready is low is not taken.
- R2: With `sched_rowfirst` = 0, the request loaded from the chosen queue is always the oldest one in that queue.
- R3: With `sched_rowfirst` = 1, the loaded request is the oldest entry of the chosen queue whose row equals the open row recorded for its {rank, bank}. When no entry hits, the oldest entry is loaded.
- R4: While not draining, a read is loaded whenever the read queue is non-empty. Writes are loaded only when the read queue is empty.
- R5: Draining begins on the clock after the write count is at least ceil(DEPTH*WR_PCT/100), which is 23 by default. While draining and the write queue is non-empty, only writes are loaded.
- R6: Draining ends on the clock after the write count is below half the entry mark (11 by default). The empty queue is included in this case.
- R7: A request whose direction (read or write) differs from the previously loaded one is loaded only after at least TURN_CYC (6) clock edges without a load since that previous load.
- R8: An accepted read whose {rank, bank, row, col} equals an entry in the write queue is not queued. The next cycle, `fwd_valid` pulses for one cycle with that read's address on the `fwd_*` outputs.
- R9: When a request is loaded, its bank's row table entry takes the request's row. The entry is marked open when `page_close` = 0 and closed when `page_close` = 1.
- R10: `fb_valid` sets the {`fb_rank`, `fb_bank`} table entry to `fb_row`, open or closed per `fb_open`. If a load updates the same bank in the same cycle, the load wins.
- R11: The output is registered. While `out_valid` is high and `out_ready` is low, the output fields are held. After a handshake, `out_valid` is low for at least one cycle.
- R12: After synchronous reset, `out_valid` and `fwd_valid` are low, both readies are high, and no row is recorded open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_rowfirst | input | 1 | 1: prefer open-row hits; 0: strict age order |
| page_close | input | 1 | 1: close row after each issue; 0: leave open |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue can accept |
| rd_rank | input | RK_W | Read rank |
| rd_bank | input | BK_W | Read bank |
| rd_row | input | ROW_W | Read row |
| rd_col | input | COL_W | Read column |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write queue can accept |
| wr_rank | input | RK_W | Write rank |
| wr_bank | input | BK_W | Write bank |
| wr_row | input | ROW_W | Write row |
| wr_col | input | COL_W | Write column |
| fb_valid | input | 1 | Row-state feedback strobe |
| fb_open | input | 1 | Feedback: 1 row opened, 0 row closed |
| fb_rank | input | RK_W | Feedback rank |
| fb_bank | input | BK_W | Feedback bank |
| fb_row | input | ROW_W | Feedback row |
| out_valid | output | 1 | Selected request valid |
| out_ready | input | 1 | Downstream takes the request |
| out_write | output | 1 | Selected request is a write |
| out_rank | output | RK_W | Selected rank |
| out_bank | output | BK_W | Selected bank |
| out_row | output | ROW_W | Selected row |
| out_col | output | COL_W | Selected column |
| fwd_valid | output | 1 | Read answered from write queue |
| fwd_rank | output | RK_W | Forwarded read rank |
| fwd_bank | output | BK_W | Forwarded read bank |
| fwd_row | output | ROW_W | Forwarded read row |
| fwd_col | output | COL_W | Forwarded read column |

## Verification
The hardest situation to reach is the start and end of a drain while reads also wait. This needs more than twenty queued writes, a read backlog, and a turnaround gap that delays the switch back. The stimulus gets there by holding `out_ready` low while both queues fill to capacity, and then releasing the output with a trickle of new reads. Row-first selection and the forward path are driven with a small address space, so that open-row hits and exact address matches happen often. A behavioural model in the bench tracks every queue, the row table and the drain state, and each cycle is compared against it.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // smallest count that reaches pct percent of depth
  function automatic int pct_mark(input int depth, input int pct);
    return (depth * pct + 99) / 100;
  endfunction

endpackage

// File: rtl/dsched_queue.sv
module dsched_queue
  import dsched_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int BI_W  = 4,
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  localparam int NB    = 1 << BI_W,
  localparam int EW    = BI_W + ROW_W + COL_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = safe_clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [EW-1:0]    push_data,
  input  logic             pop,
  input  logic             row_first,
  input  logic [NB-1:0]    open_vld,
  input  logic [ROW_W-1:0] open_row [NB],
  input  logic [EW-1:0]    query,
  output logic             query_hit,
  output logic [CNT_W-1:0] count,
  output logic [EW-1:0]    sel_data
);

  logic [EW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [DEPTH-1:0] live_m, hit_m, match_m;
  logic [IDX_W-1:0] hit_idx, sel_idx, wr_pos;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [BI_W-1:0]  ent_bank;
    logic [ROW_W-1:0] ent_row;
    assign ent_bank   = mem[g][EW-1 -: BI_W];
    assign ent_row    = mem[g][COL_W +: ROW_W];
    assign live_m[g]  = CNT_W'(g) < cnt;
    assign hit_m[g]   = live_m[g] && open_vld[ent_bank] && (open_row[ent_bank] == ent_row);
    assign match_m[g] = live_m[g] && (mem[g] == query);
  end

  // lowest index (oldest entry) with an open-row hit
  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_m[i]) hit_idx = IDX_W'(i);
    end
  end

  assign sel_idx   = (row_first && (|hit_m)) ? hit_idx : '0;
  assign sel_data  = mem[sel_idx];
  assign query_hit = |match_m;
  assign count     = cnt;
  assign wr_pos    = IDX_W'(cnt - CNT_W'(pop));

  // age order kept by closing the gap left by a removed entry
  always_ff @(posedge clk) begin
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= sel_idx) mem[i] <= mem[i+1];
      end
    end
    if (push) mem[wr_pos] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
  end

endmodule

// File: rtl/dsched_rowtbl.sv
module dsched_rowtbl #(
  parameter int BI_W  = 4,
  parameter int ROW_W = 14,
  localparam int NB   = 1 << BI_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_valid,
  input  logic             fb_open,
  input  logic [BI_W-1:0]  fb_idx,
  input  logic [ROW_W-1:0] fb_row,
  input  logic             up_valid,
  input  logic             up_open,
  input  logic [BI_W-1:0]  up_idx,
  input  logic [ROW_W-1:0] up_row,
  output logic [NB-1:0]    open_vld,
  output logic [ROW_W-1:0] open_row [NB]
);

  // feedback first, the scheduler's own update last so it wins on a tie
  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld <= '0;
    end else begin
      if (fb_valid) begin
        open_vld[fb_idx] <= fb_open;
        open_row[fb_idx] <= fb_row;
      end
      if (up_valid) begin
        open_vld[up_idx] <= up_open;
        open_row[up_idx] <= up_row;
      end
    end
  end

endmodule

// File: rtl/dsched_ctrl.sv
module dsched_ctrl
  import dsched_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int THRESH   = 23,
  parameter int LOW      = 11,
  parameter int TURN_CYC = 6,
  localparam int GAP_W   = safe_clog2(TURN_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             slot_free,
  output logic             load,
  output logic             load_wr,
  output logic             drain
);

  dir_e             last_dir;
  logic [GAP_W-1:0] gap;
  logic             pending, want_wr, turn_ok;

  always_comb begin
    pending = (rd_cnt != '0) || (wr_cnt != '0);
    want_wr = (drain || (rd_cnt == '0)) && (wr_cnt != '0);
    turn_ok = (gap == '0) || (want_wr == (last_dir == DIR_WRITE));
    load    = slot_free && pending && turn_ok;
    load_wr = want_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap      <= '0;
      last_dir <= DIR_READ;
    end else if (load) begin
      gap      <= GAP_W'(TURN_CYC);
      last_dir <= want_wr ? DIR_WRITE : DIR_READ;
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end
  end

  // hysteresis: enter at the high mark, leave below half of it
  always_ff @(posedge clk) begin
    if (rst)                                 drain <= 1'b0;
    else if (!drain && wr_cnt >= CNT_W'(THRESH)) drain <= 1'b1;
    else if (drain && wr_cnt < CNT_W'(LOW))      drain <= 1'b0;
  end

endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
  import dsched_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int WR_PCT   = 70,
  parameter int TURN_CYC = 6,
  parameter int RANKS    = 2,
  parameter int BANKS    = 8,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  localparam int RK_W    = safe_clog2(RANKS),
  localparam int BK_W    = safe_clog2(BANKS),
  localparam int BI_W    = RK_W + BK_W,
  localparam int NB      = 1 << BI_W,
  localparam int EW      = BI_W + ROW_W + COL_W,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int THRESH  = pct_mark(DEPTH, WR_PCT),
  localparam int LOW     = (THRESH >= 2) ? THRESH / 2 : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sched_rowfirst,
  input  logic             page_close,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [RK_W-1:0]  rd_rank,
  input  logic [BK_W-1:0]  rd_bank,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [RK_W-1:0]  wr_rank,
  input  logic [BK_W-1:0]  wr_bank,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic             fb_valid,
  input  logic             fb_open,
  input  logic [RK_W-1:0]  fb_rank,
  input  logic [BK_W-1:0]  fb_bank,
  input  logic [ROW_W-1:0] fb_row,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_write,
  output logic [RK_W-1:0]  out_rank,
  output logic [BK_W-1:0]  out_bank,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col,
  output logic             fwd_valid,
  output logic [RK_W-1:0]  fwd_rank,
  output logic [BK_W-1:0]  fwd_bank,
  output logic [ROW_W-1:0] fwd_row,
  output logic [COL_W-1:0] fwd_col
);

  logic [EW-1:0]    rd_data, wr_data, rq_sel, wq_sel, pick, out_data, fwd_data;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  logic             rd_acc, wr_acc, fwd_hit, rdq_match_unused;
  logic             load, load_wr, drain;
  logic [NB-1:0]    open_vld;
  logic [ROW_W-1:0] open_row [NB];

  assign rd_data  = {rd_rank, rd_bank, rd_row, rd_col};
  assign wr_data  = {wr_rank, wr_bank, wr_row, wr_col};
  assign rd_ready = rd_cnt < CNT_W'(DEPTH);
  assign wr_ready = wr_cnt < CNT_W'(DEPTH);
  assign rd_acc   = rd_valid && rd_ready;
  assign wr_acc   = wr_valid && wr_ready;

  dsched_queue #(.DEPTH(DEPTH), .BI_W(BI_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_rdq (
    .clk(clk), .rst(rst),
    .push(rd_acc && !fwd_hit), .push_data(rd_data),
    .pop(load && !load_wr), .row_first(sched_rowfirst),
    .open_vld(open_vld), .open_row(open_row),
    .query(EW'(0)), .query_hit(rdq_match_unused),
    .count(rd_cnt), .sel_data(rq_sel)
  );

  dsched_queue #(.DEPTH(DEPTH), .BI_W(BI_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_wrq (
    .clk(clk), .rst(rst),
    .push(wr_acc), .push_data(wr_data),
    .pop(load && load_wr), .row_first(sched_rowfirst),
    .open_vld(open_vld), .open_row(open_row),
    .query(rd_data), .query_hit(fwd_hit),
    .count(wr_cnt), .sel_data(wq_sel)
  );

  dsched_ctrl #(.CNT_W(CNT_W), .THRESH(THRESH), .LOW(LOW), .TURN_CYC(TURN_CYC)) u_ctrl (
    .clk(clk), .rst(rst),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .slot_free(!out_valid),
    .load(load), .load_wr(load_wr), .drain(drain)
  );

  assign pick = load_wr ? wq_sel : rq_sel;

  dsched_rowtbl #(.BI_W(BI_W), .ROW_W(ROW_W)) u_rowtbl (
    .clk(clk), .rst(rst),
    .fb_valid(fb_valid), .fb_open(fb_open), .fb_idx({fb_rank, fb_bank}), .fb_row(fb_row),
    .up_valid(load), .up_open(!page_close),
    .up_idx(pick[EW-1 -: BI_W]), .up_row(pick[COL_W +: ROW_W]),
    .open_vld(open_vld), .open_row(open_row)
  );

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (load)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_data  <= pick;
      out_write <= load_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fwd_valid <= 1'b0;
    else     fwd_valid <= rd_acc && fwd_hit;
  end

  always_ff @(posedge clk) begin
    if (rd_acc) fwd_data <= rd_data;
  end

  assign {out_rank, out_bank, out_row, out_col} = out_data;
  assign {fwd_rank, fwd_bank, fwd_row, fwd_col} = fwd_data;

endmodule

// File: rtl/dsched_chk.sv
module dsched_chk #(
  parameter int DEPTH    = 32,
  parameter int CNT_W    = 6,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int TURN_CYC = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             fwd_hit,
  input logic [CNT_W-1:0] rd_cnt,
  input logic [CNT_W-1:0] wr_cnt,
  input logic             load,
  input logic             load_wr,
  input logic             drain,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_write,
  input logic [ROW_W-1:0] out_row,
  input logic [COL_W-1:0] out_col
);

  int   since;
  logic seen, prev_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      since   <= 0;
      seen    <= 1'b0;
      prev_wr <= 1'b0;
    end else if (load) begin
      since   <= 0;
      seen    <= 1'b1;
      prev_wr <= load_wr;
    end else if (since < TURN_CYC) begin
      since <= since + 1;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_cnt <= CNT_W'(DEPTH)) && (wr_cnt <= CNT_W'(DEPTH)));

  p_read_first_r4: assert property (@(posedge clk) disable iff (rst)
    load && !drain && (rd_cnt != '0) |-> !load_wr);

  p_drain_writes_r5: assert property (@(posedge clk) disable iff (rst)
    load && drain && (wr_cnt != '0) |-> load_wr);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
    load && seen && (load_wr != prev_wr) |-> since >= TURN_CYC);

  p_fwd_not_queued_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_ready && fwd_hit |=>
      rd_cnt == $past(rd_cnt) - CNT_W'($past(load && !load_wr)));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=>
      out_valid && $stable(out_write) && $stable(out_row) && $stable(out_col));

  p_bubble_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid);

endmodule

bind dram_req_sched dsched_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .ROW_W(ROW_W), .COL_W(COL_W), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready), .fwd_hit(fwd_hit),
  .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .load(load), .load_wr(load_wr), .drain(drain),
  .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
  .out_row(out_row), .out_col(out_col)
);

// File: tb/tb_dram_req_sched.sv
module tb_dram_req_sched;

  localparam int DEPTH  = 32;
  localparam int TURN   = 6;
  localparam int THRESH = 23;
  localparam int LOW    = 11;
  localparam int RK_W = 1, BK_W = 3, ROW_W = 14, COL_W = 10;
  localparam int BI_W = RK_W + BK_W;
  localparam int NB   = 16;
  localparam int EW   = BI_W + ROW_W + COL_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic sched_rowfirst, page_close;
  logic rd_valid, rd_ready, wr_valid, wr_ready;
  logic [RK_W-1:0] rd_rank, wr_rank, fb_rank, out_rank, fwd_rank;
  logic [BK_W-1:0] rd_bank, wr_bank, fb_bank, out_bank, fwd_bank;
  logic [ROW_W-1:0] rd_row, wr_row, fb_row, out_row, fwd_row;
  logic [COL_W-1:0] rd_col, wr_col, out_col, fwd_col;
  logic fb_valid, fb_open, out_valid, out_ready, out_write, fwd_valid;

  dram_req_sched dut (
    .clk(clk), .rst(rst), .sched_rowfirst(sched_rowfirst), .page_close(page_close),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_rank(rd_rank), .rd_bank(rd_bank),
    .rd_row(rd_row), .rd_col(rd_col),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_rank(wr_rank), .wr_bank(wr_bank),
    .wr_row(wr_row), .wr_col(wr_col),
    .fb_valid(fb_valid), .fb_open(fb_open), .fb_rank(fb_rank), .fb_bank(fb_bank),
    .fb_row(fb_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_rank(out_rank), .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .fwd_valid(fwd_valid), .fwd_rank(fwd_rank), .fwd_bank(fwd_bank),
    .fwd_row(fwd_row), .fwd_col(fwd_col)
  );

  // behavioural reference state
  logic [EW-1:0]    rq[$];
  logic [EW-1:0]    wq[$];
  bit               ov[NB];
  logic [ROW_W-1:0] orow[NB];
  bit               m_drain, m_last_wr, m_slot_v, m_slot_w, m_fv;
  int               m_gap;
  logic [EW-1:0]    m_slot, m_faddr;

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 1'b0;
  string tag     = "R12";

  task automatic report(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
  endtask

  task automatic check_cycle();
    vectors++;
    if (rd_ready !== (rq.size() < DEPTH)) report("R1", "rd_ready", 32'(rd_ready), 32'(rq.size() < DEPTH));
    if (wr_ready !== (wq.size() < DEPTH)) report("R1", "wr_ready", 32'(wr_ready), 32'(wq.size() < DEPTH));
    if (out_valid !== m_slot_v) report(tag, "out_valid", 32'(out_valid), 32'(m_slot_v));
    if (m_slot_v && out_valid) begin
      if (out_write !== m_slot_w) report(tag, "out_write", 32'(out_write), 32'(m_slot_w));
      if ({out_rank, out_bank, out_row, out_col} !== m_slot)
        report(tag, "out_addr", 32'({out_rank, out_bank, out_row, out_col}), 32'(m_slot));
    end
    if (fwd_valid !== m_fv) report("R8", "fwd_valid", 32'(fwd_valid), 32'(m_fv));
    if (m_fv && fwd_valid && ({fwd_rank, fwd_bank, fwd_row, fwd_col} !== m_faddr))
      report("R8", "fwd_addr", 32'({fwd_rank, fwd_bank, fwd_row, fwd_col}), 32'(m_faddr));
  endtask

  function automatic int pick_idx(input logic [EW-1:0] q[$], input bit rf);
    if (rf) begin
      for (int i = 0; i < q.size(); i++) begin
        logic [BI_W-1:0] b;
        b = q[i][EW-1 -: BI_W];
        if (ov[b] && orow[b] == q[i][COL_W +: ROW_W]) return i;
      end
    end
    return 0;
  endfunction

  // mirrors what the next rising edge must do, from the requirements
  task automatic step();
    int rc, wc, idx;
    bit acc_r, acc_w, hit, want, pend, ld;
    logic [EW-1:0] rdat, wdat, ent;
    logic [BI_W-1:0] b;
    rc = rq.size();
    wc = wq.size();
    rdat = {rd_rank, rd_bank, rd_row, rd_col};
    wdat = {wr_rank, wr_bank, wr_row, wr_col};
    acc_r = rd_valid && (rc < DEPTH);
    acc_w = wr_valid && (wc < DEPTH);
    hit = 1'b0;
    foreach (wq[i]) if (wq[i] == rdat) hit = 1'b1;
    want = (m_drain || rc == 0) && wc != 0;
    pend = (rc != 0) || (wc != 0);
    ld = !m_slot_v && pend && (m_gap == 0 || want == m_last_wr);
    ent = '0;
    if (ld) begin
      if (want) begin
        idx = pick_idx(wq, sched_rowfirst);
        ent = wq[idx];
        wq.delete(idx);
      end else begin
        idx = pick_idx(rq, sched_rowfirst);
        ent = rq[idx];
        rq.delete(idx);
      end
    end
    if (ld) begin
      m_slot_v = 1'b1;
      m_slot   = ent;
      m_slot_w = want;
    end else if (out_ready) begin
      m_slot_v = 1'b0;
    end
    if (fb_valid) begin
      ov[{fb_rank, fb_bank}]   = fb_open;
      orow[{fb_rank, fb_bank}] = fb_row;
    end
    if (ld) begin
      b = ent[EW-1 -: BI_W];
      ov[b]   = !page_close;
      orow[b] = ent[COL_W +: ROW_W];
    end
    if (acc_r && !hit) rq.push_back(rdat);
    if (acc_w) wq.push_back(wdat);
    m_fv = acc_r && hit;
    if (acc_r) m_faddr = rdat;
    if (ld) begin
      m_gap = TURN;
      m_last_wr = want;
    end else if (m_gap > 0) begin
      m_gap--;
    end
    if (!m_drain && wc >= THRESH) m_drain = 1'b1;
    else if (m_drain && wc < LOW) m_drain = 1'b0;
  endtask

  task automatic run(input string t, input int n, input int prd, input int pwr,
                     input int prdy, input int pfb, input bit rf, input bit cp,
                     input int nrow);
    tag = t;
    for (int c = 0; c < n; c++) begin
      sched_rowfirst = rf;
      page_close = cp;
      rd_valid = ($urandom_range(99) < prd);
      rd_rank  = RK_W'($urandom_range(1));
      rd_bank  = BK_W'($urandom_range(1));
      rd_row   = ROW_W'($urandom_range(nrow - 1));
      rd_col   = COL_W'($urandom_range(3));
      wr_valid = ($urandom_range(99) < pwr);
      wr_rank  = RK_W'($urandom_range(1));
      wr_bank  = BK_W'($urandom_range(1));
      wr_row   = ROW_W'($urandom_range(nrow - 1));
      wr_col   = COL_W'($urandom_range(3));
      out_ready = ($urandom_range(99) < prdy);
      fb_valid = ($urandom_range(99) < pfb);
      fb_open  = 1'($urandom_range(1));
      fb_rank  = RK_W'($urandom_range(1));
      fb_bank  = BK_W'($urandom_range(1));
      fb_row   = ROW_W'($urandom_range(nrow - 1));
      step();
      @(negedge clk);
      check_cycle();
    end
  endtask

  initial begin
    rst = 1'b1;
    sched_rowfirst = 1'b0; page_close = 1'b0;
    rd_valid = 1'b0; wr_valid = 1'b0; fb_valid = 1'b0; fb_open = 1'b0;
    rd_rank = '0; rd_bank = '0; rd_row = '0; rd_col = '0;
    wr_rank = '0; wr_bank = '0; wr_row = '0; wr_col = '0;
    fb_rank = '0; fb_bank = '0; fb_row = '0; out_ready = 1'b0;
    m_drain = 1'b0; m_last_wr = 1'b0; m_slot_v = 1'b0; m_slot_w = 1'b0;
    m_fv = 1'b0; m_gap = 0; m_slot = '0; m_faddr = '0;
    for (int i = 0; i < NB; i++) begin ov[i] = 1'b0; orow[i] = '0; end
    repeat (3) @(negedge clk);
    check_cycle();                                   // R12 reset state
    rst = 1'b0;
    run("R2",  300, 60,  0,  50,  0, 1'b0, 1'b0, 4);    // strict age order
    run("R11", 300, 30, 20,  30,  0, 1'b0, 1'b0, 8);    // held output under back-pressure
    run("R3",  600, 50, 20,  60,  0, 1'b1, 1'b0, 3);    // open-row hits first
    run("R10", 400, 40, 20,  50, 40, 1'b1, 1'b0, 3);    // feedback updates
    run("R9",  300, 40, 20,  60, 10, 1'b1, 1'b1, 3);    // close page policy
    run("R9",  200, 40, 20,  60, 10, 1'b1, 1'b0, 3);    // back to open policy
    run("R1",  120, 95, 95,   0,  0, 1'b1, 1'b0, 64);   // both queues fill up
    run("R5",   30, 30,  0, 100,  0, 1'b1, 1'b0, 64);   // drain starts
    run("R6",  300, 30,  0, 100,  0, 1'b0, 1'b0, 64);   // drain ends, reads resume
    run("R4",  400, 20, 20, 100,  0, 1'b0, 1'b0, 64);   // reads ahead of writes
    run("R7",  400, 50, 50, 100,  0, 1'b1, 1'b0, 16);   // direction switches
    run("R8",  300, 50, 50,  70,  0, 1'b0, 1'b0, 1);    // forwarding
    run("R2",  200,  0,  0, 100,  0, 1'b0, 1'b0, 1);    // empty out
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule